// File: doc/BRIEF.md
# Floppy Controller Register File

This block is the byte-wide, memory-mapped register front end of a floppy disk controller. Software reaches it through a simple single-cycle bus. It holds a down-counting timer, a drive-select register, a control register, a sticky interrupt flag register, an interrupt-enable mask and an error register. The data path logic beside it drives single-cycle event pulses, and this block turns them into sticky flags. It combines the flags into one interrupt line and drives the drive phase lines, the strobe and the enable levels.

Software cannot write the control register directly. One write address sets the bits written as ones, and a second write address clears them. Either address reads back the current control value, so no read-modify-write sequence is needed. The flag register and the error register clear when they are read. An event that arrives in the same cycle as that read is kept for the next read. The timer counts at a fixed 1 MHz rate, derived from the system clock by a prescaler. It stops at zero and raises its own flag when it gets there.

Every access completes in the cycle it is presented and nothing applies back-pressure. A read returns its data one cycle later, with `bus_rvalid` high for one cycle.

Top module: `fdc_regblock`

## Requirements
- R1: After reset every register reads zero, and `irq`, the phase lines, the strobe and the four control outputs are low.
- R2: The register index is `bus_addr[ADDR_W-1:4]` and the low nibble is ignored, so registers sit 16 bytes apart. Index 0 is the timer, 1 is select, 2 is the control-clear port, 3 is the control-set port, 4 is the flags, 5 is errors and 6 is the interrupt enable. Other indices read 0x00. Read data appears on `bus_rdata` with `bus_rvalid` one cycle after the access.
- R3: A write to index 2 clears every control bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to index 3 sets every control bit written as 1 and leaves bits written as 0 unchanged. Reads of index 2 and index 3 both return the control value.
- R5: Control bit 0 is interrupt enable, bit 1 drives `drive_en`, bit 2 drives `drive2_en`, bit 3 drives `do_action` and bit 4 drives `write_sectors`. Bits 7:5 read 0.
- R6: In the select register, bits 2:0 drive `drv_phase` and bit 3 drives `drv_strobe`. Bits 7:4 read 0.
- R7: The flag bits are: bit 0 timer done, bit 1 seek done (`evt_seek_done`), bit 2 sector seen (`evt_sector_seen`), bit 3 transfer done (`evt_xfer_done`), bit 4 data changed (`evt_data_changed`) and bit 5 error. A one-cycle event pulse sets its flag, and the flag stays set.
- R8: A read of the flag register returns the flags and clears them. An event in the same cycle as that read stays set.
- R9: The error register keeps only bits 7 (data CRC), 6 (address CRC), 2 (overrun) and 0 (underrun) of `err_event`, and these bits are sticky. A read returns the value and clears it, but an error in the same cycle as the read stays set. Any kept error bit being raised also sets flag bit 5.
- R10: A write of N to the timer makes it count down by one every PRESCALE cycles. Timer-done is set exactly N*PRESCALE cycles after the write edge. The count then holds at zero, and a write of 0 never sets timer-done.
- R11: `irq` is high exactly when control bit 0 is set and some flag bit is set whose bit in the interrupt-enable register (bits 5:0) is also set.
- R12: Writes to the flag and error registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| evt_seek_done | input | 1 | Seek completed pulse |
| evt_sector_seen | input | 1 | Sector header passed pulse |
| evt_xfer_done | input | 1 | Transfer completed pulse |
| evt_data_changed | input | 1 | Media/data change pulse |
| err_event | input | 8 | Error pulses, bit positions as in R9 |
| irq | output | 1 | Interrupt request |
| drv_phase | output | 3 | Drive phase select lines |
| drv_strobe | output | 1 | Drive strobe line |
| drive_en | output | 1 | First drive enable |
| drive2_en | output | 1 | Second drive enable |
| do_action | output | 1 | Start the selected action |
| write_sectors | output | 1 | Transfer direction is write |

## Verification
A read that clears the flags or the errors can land in the same cycle as a hardware event that sets one of the same bits. The bench provokes this by driving a flag-register read and a sector-seen pulse toward the same clock edge. It does the same with an error-register read and an overrun pulse. Each colliding read must return the value from before the event, and a second read must show the new bit still set. The timer expiring while interrupts are enabled is also timed to the exact cycle through `irq`.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int IDX_W = 4;
  localparam int N_REGS = 7;

  localparam logic [IDX_W-1:0] IDX_TIMER    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SELECT   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL_CLR = 4'd2;
  localparam logic [IDX_W-1:0] IDX_CTRL_SET = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FLAGS    = 4'd4;
  localparam logic [IDX_W-1:0] IDX_ERROR    = 4'd5;
  localparam logic [IDX_W-1:0] IDX_IEN      = 4'd6;

  localparam int CTRL_W = 5;
  localparam int CB_IRQ_EN   = 0;
  localparam int CB_DRV1     = 1;
  localparam int CB_DRV2     = 2;
  localparam int CB_ACTION   = 3;
  localparam int CB_WRITE    = 4;

  localparam int FLAG_W = 6;
  localparam int FB_TIMER  = 0;
  localparam int FB_SEEK   = 1;
  localparam int FB_SECTOR = 2;
  localparam int FB_XFER   = 3;
  localparam int FB_CHANGE = 4;
  localparam int FB_ERROR  = 5;

  localparam int SEL_W = 4;
  localparam logic [7:0] ERR_KEEP = 8'hC5;
endpackage

// File: rtl/fdc_bus_decode.sv
module fdc_bus_decode #(
  parameter int IDX_W  = 4,
  parameter int N_REGS = 7
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  output logic [N_REGS-1:0] wr_hit,
  output logic [N_REGS-1:0] rd_hit
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_hit
    assign wr_hit[g] = sel &  wr & (idx == IDX_W'(g));
    assign rd_hit[g] = sel & ~wr & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/fdc_tick_timer.sv
module fdc_tick_timer #(
  parameter int PRESCALE = 50,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick   = (pre_q == PRE_LAST);
  assign expire = !load && (count == CNT_W'(1)) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else if (load) begin
      pre_q <= '0;
      count <= load_val;
    end else if (count != '0) begin
      if (tick) begin
        pre_q <= '0;
        count <= count - CNT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/fdc_sticky_bits.sv
module fdc_sticky_bits #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd_clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (rd_clr) q <= set_vec;
    else             q <= q | set_vec;
  end
endmodule

// File: rtl/fdc_ctrl_bits.sv
module fdc_ctrl_bits #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_we ? mask : '0;
  assign clr_m = clr_we ? mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/fdc_regblock.sv
module fdc_regblock
  import fdc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic              evt_seek_done,
  input  logic              evt_sector_seen,
  input  logic              evt_xfer_done,
  input  logic              evt_data_changed,
  input  logic [7:0]        err_event,
  output logic              irq,
  output logic [2:0]        drv_phase,
  output logic              drv_strobe,
  output logic              drive_en,
  output logic              drive2_en,
  output logic              do_action,
  output logic              write_sectors
);
  localparam int AIDX_W = ADDR_W - 4;

  logic [AIDX_W-1:0] idx;
  logic [N_REGS-1:0] wr_hit, rd_hit;
  logic [CTRL_W-1:0] ctrl_q;
  logic [FLAG_W-1:0] flags_q, flag_set;
  logic [7:0]        err_q, err_set;
  logic [7:0]        timer_cnt;
  logic              timer_expire;
  logic [SEL_W-1:0]  sel_q;
  logic [FLAG_W-1:0] ien_q;
  logic [7:0]        rd_mux;

  assign idx = bus_addr[ADDR_W-1:4];

  fdc_bus_decode #(.IDX_W(AIDX_W), .N_REGS(N_REGS)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .idx(idx), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  fdc_ctrl_bits #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .set_we(wr_hit[IDX_CTRL_SET]), .clr_we(wr_hit[IDX_CTRL_CLR]),
    .mask(bus_wdata[CTRL_W-1:0]), .q(ctrl_q)
  );

  fdc_tick_timer #(.PRESCALE(PRESCALE), .CNT_W(8)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(wr_hit[IDX_TIMER]), .load_val(bus_wdata),
    .count(timer_cnt), .expire(timer_expire)
  );

  assign err_set = err_event & ERR_KEEP;

  fdc_sticky_bits #(.W(8)) u_err (
    .clk(clk), .rst_n(rst_n), .set_vec(err_set),
    .rd_clr(rd_hit[IDX_ERROR]), .q(err_q)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FB_TIMER]  = timer_expire;
    flag_set[FB_SEEK]   = evt_seek_done;
    flag_set[FB_SECTOR] = evt_sector_seen;
    flag_set[FB_XFER]   = evt_xfer_done;
    flag_set[FB_CHANGE] = evt_data_changed;
    flag_set[FB_ERROR]  = |err_set;
  end

  fdc_sticky_bits #(.W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(flag_set),
    .rd_clr(rd_hit[IDX_FLAGS]), .q(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_hit[IDX_SELECT]) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_hit[IDX_IEN])    ien_q <= bus_wdata[FLAG_W-1:0];
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (rd_hit[IDX_TIMER])    rd_mux = timer_cnt;
    if (rd_hit[IDX_SELECT])   rd_mux = 8'(sel_q);
    if (rd_hit[IDX_CTRL_CLR] || rd_hit[IDX_CTRL_SET]) rd_mux = 8'(ctrl_q);
    if (rd_hit[IDX_FLAGS])    rd_mux = 8'(flags_q);
    if (rd_hit[IDX_ERROR])    rd_mux = err_q;
    if (rd_hit[IDX_IEN])      rd_mux = 8'(ien_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= 8'h00;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel & ~bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  assign irq           = ctrl_q[CB_IRQ_EN] & (|(flags_q & ien_q));
  assign drv_phase     = sel_q[2:0];
  assign drv_strobe    = sel_q[3];
  assign drive_en      = ctrl_q[CB_DRV1];
  assign drive2_en     = ctrl_q[CB_DRV2];
  assign do_action     = ctrl_q[CB_ACTION];
  assign write_sectors = ctrl_q[CB_WRITE];
endmodule

// File: rtl/fdc_regblock_chk.sv
module fdc_regblock_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              evt_seek_done,
  input logic              evt_sector_seen,
  input logic              evt_xfer_done,
  input logic              evt_data_changed,
  input logic [7:0]        err_event,
  input logic [4:0]        ctrl_q,
  input logic [5:0]        flags_q,
  input logic [7:0]        timer_cnt,
  input logic              irq
);
  logic [ADDR_W-5:0] cidx;
  assign cidx = bus_addr[ADDR_W-1:4];

  // R3
  a_r3_clear_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && cidx == 2) |=> ((ctrl_q & $past(bus_wdata[4:0])) == 5'd0));

  // R4
  a_r4_set_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && cidx == 3) |=> ((ctrl_q & $past(bus_wdata[4:0])) == $past(bus_wdata[4:0])));

  // R7
  a_r7_seek_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seek_done |=> flags_q[1]);

  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && cidx == 4 && !evt_seek_done && !evt_sector_seen &&
     !evt_xfer_done && !evt_data_changed) |=> (flags_q[4:1] == 4'd0));

  // R9
  a_r9_error_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_event & 8'hC5)) |=> flags_q[5]);

  // R10
  a_r10_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_cnt == 8'd0 && !(bus_sel && bus_wr && cidx == 0)) |=> (timer_cnt == 8'd0));

  // R11
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0]) |-> !irq);
endmodule

bind fdc_regblock fdc_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .evt_seek_done(evt_seek_done), .evt_sector_seen(evt_sector_seen),
  .evt_xfer_done(evt_xfer_done), .evt_data_changed(evt_data_changed),
  .err_event(err_event), .ctrl_q(ctrl_q), .flags_q(flags_q),
  .timer_cnt(timer_cnt), .irq(irq)
);

// File: tb/fdc_regblock_tb.sv
`timescale 1ns/1ps
module fdc_regblock_tb;
  localparam int ADDR_W = 8;
  localparam int PRE    = 3;
  localparam int NVEC   = 13;

  // entry: {is_write, idx[3:0], wdata[7:0], expected[7:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 4'd3, 8'h1F, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h1F},
    {1'b1, 4'd2, 8'h05, 8'h00},
    {1'b0, 4'd2, 8'h00, 8'h1A},
    {1'b1, 4'd3, 8'hE1, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h1B},
    {1'b1, 4'd1, 8'hFB, 8'h00},
    {1'b0, 4'd1, 8'h00, 8'h0B},
    {1'b1, 4'd6, 8'hFF, 8'h00},
    {1'b0, 4'd6, 8'h00, 8'h3F},
    {1'b0, 4'd9, 8'h00, 8'h00},
    {1'b1, 4'd2, 8'hFF, 8'h00},
    {1'b0, 4'd3, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;
  logic evt_seek_done = 0, evt_sector_seen = 0, evt_xfer_done = 0, evt_data_changed = 0;
  logic [7:0] err_event = '0;
  logic irq, drv_strobe, drive_en, drive2_en, do_action, write_sectors;
  logic [2:0] drv_phase;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdc_regblock #(.ADDR_W(ADDR_W), .PRESCALE(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_seek_done(evt_seek_done),
    .evt_sector_seen(evt_sector_seen), .evt_xfer_done(evt_xfer_done),
    .evt_data_changed(evt_data_changed), .err_event(err_event), .irq(irq),
    .drv_phase(drv_phase), .drv_strobe(drv_strobe), .drive_en(drive_en),
    .drive2_en(drive2_en), .do_action(do_action), .write_sectors(write_sectors)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      failures++;
      $display("FAIL R2 rvalid actual=%0b expected=1", bus_rvalid);
    end
  endtask

  task automatic pulse(input logic [3:0] evs, input logic [7:0] errs);
    @(negedge clk);
    {evt_data_changed, evt_xfer_done, evt_sector_seen, evt_seek_done} = evs;
    err_event = errs;
    @(negedge clk);
    {evt_data_changed, evt_xfer_done, evt_sector_seen, evt_seek_done} = 4'b0;
    err_event = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 outputs", {drv_phase, drv_strobe, drive_en, drive2_en, do_action, write_sectors}, 8'h00);
    for (int i = 0; i < 7; i++) begin
      rd(8'(i << 4), d);
      check("R1 register", d, 8'h00);
    end

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][20]) wr({VEC[i][19:16], 4'h0}, VEC[i][15:8]);
      else begin
        rd({VEC[i][19:16], 4'h0}, d);
        check($sformatf("table vector %0d R2 R3 R4 R5 R6", i), d, VEC[i][7:0]);
      end
    end

    // R5 R6 output pins
    wr(8'h30, 8'h1E);
    check("R5 ctrl pins", {4'b0, drive_en, drive2_en, do_action, write_sectors}, 8'h0F);
    check("R6 select pins", {4'b0, drv_strobe, drv_phase}, 8'h0B);
    wr(8'h20, 8'h1E);
    check("R5 ctrl pins cleared", {4'b0, drive_en, drive2_en, do_action, write_sectors}, 8'h00);

    // R2 low nibble ignored
    wr(8'h1F, 8'h05);
    rd(8'h13, d);
    check("R2 alias", d, 8'h05);

    // R7 R8 sticky and read-to-clear
    pulse(4'b0001, 8'h00);
    rd(8'h40, d); check("R7 seek flag", d, 8'h02);
    rd(8'h40, d); check("R8 cleared", d, 8'h00);
    pulse(4'b1000, 8'h00);
    rd(8'h40, d); check("R7 change flag", d, 8'h10);

    // R8 collision: read and sector event toward the same edge
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h40; evt_sector_seen = 1;
    @(negedge clk);
    bus_sel = 0; evt_sector_seen = 0; d = bus_rdata;
    check("R8 collide read", d, 8'h00);
    rd(8'h40, d); check("R8 collide kept", d, 8'h04);

    // R9 error register
    pulse(4'b0000, 8'hFF);
    rd(8'h50, d); check("R9 kept bits", d, 8'hC5);
    rd(8'h40, d); check("R9 error flag", d, 8'h20);
    rd(8'h50, d); check("R9 cleared", d, 8'h00);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h50; err_event = 8'h04;
    @(negedge clk);
    bus_sel = 0; err_event = 0; d = bus_rdata;
    check("R9 collide read", d, 8'h00);
    rd(8'h50, d); check("R9 collide kept", d, 8'h04);
    rd(8'h40, d); check("R9 flag again", d, 8'h20);

    // R12 writes to flags/errors ignored
    pulse(4'b1000, 8'h00);
    wr(8'h40, 8'h00);
    wr(8'h50, 8'hFF);
    rd(8'h40, d); check("R12 flags unchanged", d, 8'h10);
    rd(8'h50, d); check("R12 errors unchanged", d, 8'h00);

    // R10 R11 timer expiry timed through irq
    wr(8'h60, 8'h01);
    wr(8'h30, 8'h01);
    wr(8'h00, 8'h05);
    repeat (5 * PRE - 1) @(negedge clk);
    check("R10 not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R10 expiry", {7'b0, irq}, 8'h01);
    rd(8'h00, d); check("R10 held at zero", d, 8'h00);
    rd(8'h40, d); check("R10 timer flag", d, 8'h01);
    check("R11 irq drops", {7'b0, irq}, 8'h00);

    // R11 gating
    pulse(4'b0100, 8'h00);
    check("R11 masked by ien", {7'b0, irq}, 8'h00);
    wr(8'h60, 8'h08);
    check("R11 enabled", {7'b0, irq}, 8'h01);
    wr(8'h20, 8'h01);
    check("R11 ctrl off", {7'b0, irq}, 8'h00);
    rd(8'h40, d); check("R11 xfer flag", d, 8'h08);

    // R10 write of zero
    wr(8'h00, 8'h00);
    repeat (20) @(negedge clk);
    rd(8'h40, d); check("R10 zero no flag", d, 8'h00);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule